// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block watches the access stream presented to a cache and labels each miss by its cause. Each access carries a block address and a flag that says whether the cache missed. The block keeps two private structures. The first is a set of every distinct block address seen since reset. The second is a recency-ordered list of the last N distinct block addresses, which acts as a shadow of a fully associative LRU store with N lines. For a cache with a victim buffer, N is the number of cache lines plus the number of victim lines.

A miss to an address that neither structure holds is compulsory. A miss to an address that has been seen before but has dropped out of the recency list is a capacity miss. Any other miss is a conflict miss, because a fully associative cache of the same size would have hit. The label appears one clock after the access. The seen-set has finite depth, and a sticky flag reports when more distinct addresses arrived than it could record.

Top module: `miss_classifier`

## Requirements
- R1: An access with the miss flag low produces class code 2'b00 (hit) on `out_class`.
- R2: A miss to an address not referenced since the last reset produces class code 2'b01 (compulsory).
- R3: A miss to an address referenced since reset but absent from the last LRU_DEPTH distinct addresses produces class code 2'b10 (capacity).
- R4: A miss to an address among the last LRU_DEPTH distinct addresses produces class code 2'b11 (conflict). This includes an immediate repeat of the previous address.
- R5: Every access, hit or miss, moves its address to the most-recent end of the recency list. A hit therefore protects its address from the next eviction.
- R6: An access to an address not in the recency list, made while the list holds LRU_DEPTH entries, drops the least recently used entry.
- R7: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. When `out_valid` is low, `out_class` is 2'b00.
- R8: The seen-set records up to SEEN_DEPTH distinct addresses. An access to a new address while the set is full raises `seen_overflow`, which stays high until reset. An address that was not recorded and has left the recency list is again reported as compulsory.
- R9: A synchronous reset empties the seen-set and the recency list, clears `seen_overflow`, and holds `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An access is presented this cycle |
| in_addr | input | ADDR_W | Block address of the access |
| in_miss | input | 1 | The cache missed on this access |
| out_valid | output | 1 | Class code valid, one cycle after the access |
| out_class | output | 2 | 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| seen_overflow | output | 1 | Sticky: the seen-set ran out of room |

## Verification
The properties assume that `in_valid` stays low while reset is asserted and that LRU_DEPTH is at least one. Under that assumption, an immediate repeat of a missed address is always found in the recency list. The bench drives inputs only on the falling edge and holds `in_valid` low throughout every reset pulse. Its address pool stays well inside SEEN_DEPTH except in one dedicated phase that deliberately overfills the seen-set.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
   typedef enum logic [1:0] {
      CLS_HIT   = 2'b00,
      CLS_FIRST = 2'b01,
      CLS_CAPAC = 2'b10,
      CLS_CONFL = 2'b11
   } miss_cls_e;
endpackage

// File: rtl/mcc_seen_set.sv
module mcc_seen_set #(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              probe_en,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              found,
   output logic              overflow
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [ADDR_W-1:0] slot [DEPTH];
   logic [CW-1:0]     fill;
   logic              full;
   logic              record;

   always_comb begin
      found = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (i < int'(fill) && slot[i] == probe_addr) found = 1'b1;
      end
   end

   assign full   = (fill == CW'(DEPTH));
   assign record = probe_en && !found && !full;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst)                              slot[g] <= '0;
         else if (record && fill == CW'(g))    slot[g] <= probe_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fill     <= '0;
         overflow <= 1'b0;
      end else begin
         if (record) fill <= fill + 1'b1;
         if (probe_en && !found && full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/mcc_recency_list.sv
module mcc_recency_list #(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              touch_en,
   input  logic [ADDR_W-1:0] touch_addr,
   output logic              present
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [ADDR_W-1:0] tag  [DEPTH];
   logic [DEPTH-1:0]  live;
   logic [DEPTH-1:0]  hitv;
   logic [DEPTH-1:0]  shift_en;
   logic [IW-1:0]     pos;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hitv[g] = live[g] && (tag[g] == touch_addr);
   end

   assign present = |hitv;

   always_comb begin
      pos = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hitv[i]) pos = IW'(i);
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         shift_en[i] = touch_en && (!present || i <= int'(pos));
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) begin
               tag[g]  <= '0;
               live[g] <= 1'b0;
            end else if (shift_en[g]) begin
               tag[g]  <= touch_addr;
               live[g] <= 1'b1;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst) begin
               tag[g]  <= '0;
               live[g] <= 1'b0;
            end else if (shift_en[g]) begin
               tag[g]  <= tag[g-1];
               live[g] <= live[g-1];
            end
         end
      end
   end
endmodule

// File: rtl/mcc_classify.sv
module mcc_classify
   import mcc_pkg::*;
(
   input  logic      is_miss,
   input  logic      in_seen,
   input  logic      in_recent,
   output miss_cls_e cls
);
   always_comb begin
      if (!is_miss)                    cls = CLS_HIT;
      else if (!in_seen && !in_recent) cls = CLS_FIRST;
      else if (!in_recent)             cls = CLS_CAPAC;
      else                             cls = CLS_CONFL;
   end
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
   import mcc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int LRU_DEPTH  = 4,
   parameter int SEEN_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_miss,
   output logic              out_valid,
   output logic [1:0]        out_class,
   output logic              seen_overflow
);
   if (ADDR_W < 1) begin : g_bad_aw
      $error("ADDR_W must be at least 1");
   end
   if (LRU_DEPTH < 1) begin : g_bad_lru
      $error("LRU_DEPTH must be at least 1");
   end
   if (SEEN_DEPTH < LRU_DEPTH) begin : g_bad_seen
      $error("SEEN_DEPTH must not be below LRU_DEPTH");
   end

   logic      seen_hit;
   logic      recent_hit;
   miss_cls_e cls_now;

   mcc_seen_set #(.ADDR_W(ADDR_W), .DEPTH(SEEN_DEPTH)) u_seen (
      .clk        (clk),
      .rst        (rst),
      .probe_en   (in_valid),
      .probe_addr (in_addr),
      .found      (seen_hit),
      .overflow   (seen_overflow)
   );

   mcc_recency_list #(.ADDR_W(ADDR_W), .DEPTH(LRU_DEPTH)) u_recent (
      .clk        (clk),
      .rst        (rst),
      .touch_en   (in_valid),
      .touch_addr (in_addr),
      .present    (recent_hit)
   );

   mcc_classify u_cls (
      .is_miss   (in_miss),
      .in_seen   (seen_hit),
      .in_recent (recent_hit),
      .cls       (cls_now)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_class <= 2'b00;
      end else begin
         out_valid <= in_valid;
         out_class <= in_valid ? 2'(cls_now) : 2'b00;
      end
   end
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_addr,
   input logic              in_miss,
   input logic              out_valid,
   input logic [1:0]        out_class,
   input logic              seen_overflow
);
   logic armed;
   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b0;
      else     armed <= 1'b1;
   end

   p_latency_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && out_class == 2'b00));

   p_hit_code_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_miss) |=> (out_class == 2'b00));

   p_miss_code_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_miss) |=> (out_class != 2'b00));

   p_repeat_conflict_r4: assert property (@(posedge clk) disable iff (rst)
      (armed && in_valid && $past(in_valid) && in_miss && in_addr == $past(in_addr))
      |=> (out_class == 2'b11));

   p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      seen_overflow |=> seen_overflow);

   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (!out_valid && !seen_overflow && out_class == 2'b00));
endmodule

bind miss_classifier mcc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .in_valid      (in_valid),
   .in_addr       (in_addr),
   .in_miss       (in_miss),
   .out_valid     (out_valid),
   .out_class     (out_class),
   .seen_overflow (seen_overflow)
);

// File: tb/sim_miss_classifier.sv
`timescale 1ns/1ps
module sim_miss_classifier;
   localparam int AW = 12;
   localparam int N  = 4;
   localparam int S  = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          in_miss = 1'b0;
   logic          out_valid;
   logic [1:0]    out_class;
   logic          seen_overflow;

   int vectors = 0;
   int errors  = 0;
   logic [1:0] last_cls;

   int seen_q[$];
   int lru_q[$];
   bit m_ovf;

   always #2 clk = ~clk;

   miss_classifier #(.ADDR_W(AW), .LRU_DEPTH(N), .SEEN_DEPTH(S)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
      .in_miss(in_miss), .out_valid(out_valid), .out_class(out_class),
      .seen_overflow(seen_overflow)
   );

   task automatic chk(string tag, int act, int exp, string what);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      seen_q.delete();
      lru_q.delete();
      m_ovf = 1'b0;
   endtask

   function automatic string cls_tag(int c);
      case (c)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic access(int a, bit m);
      int in_s, in_l, exp;
      in_valid = 1'b1;
      in_addr  = AW'(a);
      in_miss  = m;
      in_s = 0;
      in_l = -1;
      foreach (seen_q[i]) if (seen_q[i] == a) in_s = 1;
      foreach (lru_q[i])  if (lru_q[i] == a) in_l = i;
      if (!m)                        exp = 0;
      else if (!in_s && in_l < 0)    exp = 1;
      else if (in_l < 0)             exp = 2;
      else                           exp = 3;
      if (!in_s) begin
         if (seen_q.size() < S) seen_q.push_back(a);
         else m_ovf = 1'b1;
      end
      if (in_l >= 0) lru_q.delete(in_l);
      lru_q.push_front(a);
      if (lru_q.size() > N) void'(lru_q.pop_back());
      @(negedge clk);
      in_valid = 1'b0;
      last_cls = out_class;
      chk("R7", int'(out_valid), 1, "out_valid after access");
      chk(cls_tag(exp), int'(out_class), exp, "class vs model");
      chk("R8", int'(seen_overflow), int'(m_ovf), "overflow vs model");
   endtask

   task automatic idle();
      in_valid = 1'b0;
      @(negedge clk);
      chk("R7", int'(out_valid), 0, "out_valid idle");
      chk("R7", int'(out_class), 0, "class idle");
   endtask

   task automatic expect_cls(int exp, string tag);
      chk(tag, int'(last_cls), exp, "directed class");
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk("R9", int'(out_valid), 0, "out_valid after reset");
      chk("R9", int'(seen_overflow), 0, "overflow after reset");
      chk("R9", int'(out_class), 0, "class after reset");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : stim
      model_reset();
      repeat (3) @(negedge clk);
      do_reset();

      // R2 first touch, R1 hit, R4 immediate repeat miss
      access(10, 1); expect_cls(1, "R2");
      access(10, 0); expect_cls(0, "R1");
      access(10, 1); expect_cls(3, "R4");
      idle();
      // R6: four more distinct addresses push 10 out
      access(11, 1); access(12, 1); access(13, 1); access(14, 1);
      expect_cls(1, "R2");
      access(10, 1); expect_cls(2, "R3");   // list now 10 14 13 12
      access(11, 1); expect_cls(2, "R6");   // 11 was evicted
      access(14, 1); expect_cls(3, "R4");   // list 14 11 10 13
      // R5: a hit refreshes 13, so the next new address evicts 10
      access(13, 0); expect_cls(0, "R5");   // list 13 14 11 10
      access(15, 1);                          // list 15 13 14 11
      access(13, 1); expect_cls(3, "R5");
      access(10, 1); expect_cls(2, "R6");
      idle();

      // mixed stream compared with the model every cycle
      for (int k = 0; k < 400; k++) begin
         if (($urandom % 7) == 0) idle();
         else access(int'($urandom % 10), 1'($urandom % 3 != 0));
      end

      // R8: overfill the seen-set
      do_reset();
      for (int k = 0; k < S + 1; k++) access(100 + k, 1);
      chk("R8", int'(seen_overflow), 1, "overflow raised");
      access(100, 1); expect_cls(2, "R3");
      access(100 + S, 1); expect_cls(3, "R4");
      for (int k = 0; k < N; k++) access(200 + k, 1);
      access(100 + S, 1); expect_cls(1, "R8");
      idle();
      chk("R8", int'(seen_overflow), 1, "overflow sticky");

      // R9: reset forgets history
      do_reset();
      access(100, 1); expect_cls(1, "R9");
      idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule